// File: doc/BRIEF.md
# ADC Conversion Offset and Gain Trim

This block trims every raw signed 24-bit conversion result from an ADC. It applies a signed offset coefficient and an unsigned gain coefficient, then delivers the corrected code on an output valid/data stream. The gain coefficient is a fixed-point number with 22 fraction bits, so 0x400000 stands for a gain of exactly one. A mode input picks the order of the two steps. In one order the offset is removed first and the difference is scaled. In the other the raw code is scaled first and the offset is taken away afterwards.

Software reaches both coefficients through a small register port. A calibration controller can load both coefficients in a single cycle. A host write always wins over a controller load for the register it addresses. The scaled result is rounded to nearest and clamped to the signed 24-bit range. A sticky flag records that at least one clamp has occurred since reset. The pipeline has a fixed latency of two cycles and applies no backpressure.

Top module: `adc_trim_core`

## Requirements
- R1: With `order_sel`=0 the output is sat(rnd((x - off) * gain / 2^22)), where x is the raw code, off the signed offset and gain the unsigned gain.
- R2: A gain of 0x400000 leaves the offset-corrected value unchanged, and a gain of 0x800000 doubles it.
- R3: With `order_sel`=1 the output is sat(rnd(x * gain / 2^22) - off).
- R4: Rounding adds 2^21 to the product before an arithmetic right shift by 22. Halves therefore round toward plus infinity, so +1.5 gives 2 and -1.5 gives -1.
- R5: Results above 0x7FFFFF are clamped to 0x7FFFFF, and results below -0x800000 are clamped to 0x800000. A clamp sets `ovf_flag`, which stays set until reset.
- R6: `out_valid` follows `in_valid` exactly two cycles later. `out_data` holds its value while `out_valid` is low.
- R7: Reset sets the offset to 0, the gain to 0x400000, and clears `out_valid` and `ovf_flag`.
- R8: When `reg_we` is high, `reg_wdata` is written to the offset register if `reg_sel`=0 or to the gain register if `reg_sel`=1. `reg_rdata` shows the register picked by `reg_sel` combinationally.
- R9: When `cal_load` is high, both coefficients are loaded from `cal_off` and `cal_gain`. If a host write happens in the same cycle, the register it addresses takes the host value.
- R10: The coefficients and `order_sel` are sampled together with each accepted sample. A coefficient write in the same cycle as a sample takes effect from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw sample valid |
| in_data | input | 24 | Raw signed conversion code |
| order_sel | input | 1 | 0: offset then gain, 1: gain then offset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 1 | Register select: 0 offset, 1 gain |
| reg_wdata | input | 24 | Host write data |
| reg_rdata | output | 24 | Selected register contents |
| cal_load | input | 1 | Calibration controller load strobe |
| cal_off | input | 24 | Offset value from the calibration controller |
| cal_gain | input | 24 | Gain value from the calibration controller |
| out_valid | output | 1 | Corrected sample valid |
| out_data | output | 24 | Corrected signed code |
| ovf_flag | output | 1 | Sticky clamp indicator |

## Verification
The assertions assume `in_valid` is a clean single-bit strobe with no X values after reset. They also assume `reg_sel` holds a defined value whenever `reg_we` is high, because the write checks look up the register that was addressed one cycle earlier. The bench changes every input only on the falling clock edge. It holds the register and calibration strobes low except in the cycle it chooses, so each coefficient change lands at a known point relative to the samples around it.

// File: rtl/adc_trim_core.sv
module adc_trim_core #(
  parameter int W    = 24,
  parameter int GW   = 24,
  parameter int FRAC = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic          order_sel,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          cal_load,
  input  logic [W-1:0]  cal_off,
  input  logic [GW-1:0] cal_gain,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          ovf_flag
);
  localparam int PW = W + GW + 2;
  localparam int SW = PW - FRAC;
  localparam int RW = SW + 1;
  localparam logic signed [RW-1:0] MAXV = RW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [RW-1:0] MINV = RW'(-(64'sd1 <<< (W-1)));
  localparam logic [GW-1:0] UNITY = GW'(64'd1 << FRAC);

  logic signed [W-1:0]  off_q;
  logic [GW-1:0]        gain_q;

  logic                 s1_v, s1_mode;
  logic signed [W:0]    s1_pre;
  logic signed [W-1:0]  s1_off;
  logic [GW-1:0]        s1_gain;

  logic signed [W:0]    pre;
  logic signed [PW-1:0] prod, rnd;
  logic signed [SW-1:0] sh;
  logic signed [RW-1:0] res;
  logic                 hi, lo;

  assign reg_rdata = reg_sel ? W'(gain_q) : off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      gain_q <= UNITY;
    end else begin
      if (cal_load) begin
        off_q  <= cal_off;
        gain_q <= cal_gain;
      end
      if (reg_we && !reg_sel) off_q  <= reg_wdata;
      if (reg_we &&  reg_sel) gain_q <= GW'(reg_wdata);
    end
  end

  assign pre = order_sel ? {in_data[W-1], in_data}
                         : ({in_data[W-1], in_data} - {off_q[W-1], off_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_mode <= 1'b0;
      s1_pre  <= '0;
      s1_off  <= '0;
      s1_gain <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_mode <= order_sel;
        s1_pre  <= pre;
        s1_off  <= off_q;
        s1_gain <= gain_q;
      end
    end
  end

  assign prod = PW'(s1_pre) * PW'($signed({1'b0, s1_gain}));
  assign rnd  = prod + (PW'(1) <<< (FRAC-1));
  assign sh   = rnd[PW-1:FRAC];
  assign res  = s1_mode ? ({sh[SW-1], sh} - RW'(s1_off)) : {sh[SW-1], sh};
  assign hi   = res > MAXV;
  assign lo   = res < MINV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_data <= hi ? MAXV[W-1:0] : lo ? MINV[W-1:0] : res[W-1:0];
        if (hi || lo) ovf_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_trim_core_chk.sv
module adc_trim_core_chk #(
  parameter int W  = 24,
  parameter int GW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          reg_we,
  input logic          reg_sel,
  input logic [W-1:0]  reg_wdata,
  input logic          cal_load,
  input logic [W-1:0]  cal_off,
  input logic [GW-1:0] cal_gain,
  input logic [W-1:0]  off_q,
  input logic [GW-1:0] gain_q,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          ovf_flag
);
  localparam logic [W-1:0] TOP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] BOT = {1'b1, {(W-1){1'b0}}};

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  assert_clamp_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (out_valid && (out_data == TOP || out_data == BOT)));
  assert_host_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> ($past(reg_sel) ? (gain_q == GW'($past(reg_wdata)))
                               : (off_q == $past(reg_wdata))));
  assert_cal_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_load && !reg_we) |=> (off_q == $past(cal_off) && gain_q == $past(cal_gain)));
endmodule

bind adc_trim_core adc_trim_core_chk #(.W(W), .GW(GW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cal_load(cal_load),
  .cal_off(cal_off), .cal_gain(cal_gain), .off_q(off_q), .gain_q(gain_q),
  .out_valid(out_valid), .out_data(out_data), .ovf_flag(ovf_flag));

// File: tb/adc_trim_core_tb_top.sv
module adc_trim_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic order_sel = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic cal_load = 1'b0;
  logic [23:0] cal_off = '0, cal_gain = '0;
  logic out_valid, ovf_flag;
  logic [23:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_trim_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .order_sel(order_sel), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cal_load(cal_load),
    .cal_off(cal_off), .cal_gain(cal_gain), .out_valid(out_valid),
    .out_data(out_data), .ovf_flag(ovf_flag));

  function automatic longint model(longint x, longint off, longint g, bit m);
    longint p, r;
    if (!m) begin
      p = (x - off) * g;
      r = (p + 64'sd2097152) >>> 22;
    end else begin
      p = x * g;
      r = ((p + 64'sd2097152) >>> 22) - off;
    end
    if (r > 64'sd8388607) r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_wr(bit sel, logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(string tag, int x, bit m, longint exp);
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'(x); order_sel = m;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " no valid yet"}, out_valid, 0);
    @(negedge clk);
    check({tag, " valid"}, out_valid, 1);
    check(tag, longint'($signed(out_data)), exp);
  endtask

  task automatic t_reset_R7();
    do_reset();
    reg_sel = 1'b0; #1;
    check("R7 offset reset", reg_rdata, 0);
    reg_sel = 1'b1; #1;
    check("R7 gain reset", reg_rdata, 24'h400000);
    check("R7 out_valid", out_valid, 0);
    check("R7 ovf", ovf_flag, 0);
  endtask

  task automatic t_order0_R1();
    host_wr(1'b0, 24'd100);
    host_wr(1'b1, 24'h600000);
    reg_sel = 1'b0; #1;
    check("R8 readback offset", reg_rdata, 100);
    reg_sel = 1'b1; #1;
    check("R8 readback gain", reg_rdata, 24'h600000);
    run("R1 pos", 1000, 1'b0, model(1000, 100, 24'h600000, 1'b0));
    run("R1 neg", -70000, 1'b0, model(-70000, 100, 24'h600000, 1'b0));
  endtask

  task automatic t_unity_R2();
    host_wr(1'b0, 24'(-200));
    host_wr(1'b1, 24'h400000);
    run("R2 unity", -5000, 1'b0, -4800);
    host_wr(1'b1, 24'h800000);
    run("R2 double", -5000, 1'b0, -9600);
  endtask

  task automatic t_order1_R3();
    host_wr(1'b0, 24'd100);
    host_wr(1'b1, 24'h600000);
    run("R3 gain first", 1000, 1'b1, 1400);
    run("R3 gain first neg", -3333, 1'b1, model(-3333, 100, 24'h600000, 1'b1));
    run("R1 vs R3 order switch", 1000, 1'b0, 1350);
  endtask

  task automatic t_round_R4();
    host_wr(1'b0, 24'd0);
    host_wr(1'b1, 24'h600000);
    run("R4 +1.5", 1, 1'b0, 2);
    run("R4 -1.5", -1, 1'b0, -1);
    host_wr(1'b1, 24'h500000);
    run("R4 +1.25", 1, 1'b0, 1);
    run("R4 -1.25", -1, 1'b0, -1);
  endtask

  task automatic t_sat_R5();
    do_reset();
    host_wr(1'b1, 24'h800000);
    run("R5 below limit", 24'h3FFFFF, 1'b0, 24'h7FFFFE);
    check("R5 no ovf", ovf_flag, 0);
    run("R5 clamp hi", 24'h700000, 1'b0, 8388607);
    check("R5 ovf set", ovf_flag, 1);
    run("R5 normal after", 10, 1'b0, 20);
    check("R5 ovf sticky", ovf_flag, 1);
    do_reset();
    check("R5 ovf cleared", ovf_flag, 0);
    host_wr(1'b0, 24'd5000);
    run("R5 clamp lo", -8388608, 1'b0, -8388608);
    check("R5 ovf lo", ovf_flag, 1);
  endtask

  task automatic t_cal_R9();
    do_reset();
    @(negedge clk);
    cal_load = 1'b1; cal_off = 24'd7; cal_gain = 24'h200000;
    @(negedge clk);
    cal_load = 1'b0;
    run("R9 cal values", 107, 1'b0, 50);
    @(negedge clk);
    cal_load = 1'b1; cal_off = 24'd1; cal_gain = 24'h800000;
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 24'd3;
    @(negedge clk);
    cal_load = 1'b0; reg_we = 1'b0;
    reg_sel = 1'b0; #1;
    check("R9 host wins offset", reg_rdata, 3);
    reg_sel = 1'b1; #1;
    check("R9 cal gain kept", reg_rdata, 24'h800000);
  endtask

  task automatic t_midstream_R10();
    do_reset();
    host_wr(1'b0, 24'd10);
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'd110; order_sel = 1'b0;
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 24'd50;
    @(negedge clk);
    in_data = 24'd110; order_sel = 1'b1;
    reg_we = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 first valid", out_valid, 1);
    check("R10 old offset", longint'($signed(out_data)), 100);
    @(negedge clk);
    check("R6 second valid", out_valid, 1);
    check("R10 new offset and mode", longint'($signed(out_data)), 60);
    @(negedge clk);
    check("R6 idle", out_valid, 0);
    check("R6 hold", longint'($signed(out_data)), 60);
  endtask

  initial begin
    t_reset_R7();
    t_order0_R1();
    t_unity_R2();
    t_order1_R3();
    t_round_R4();
    t_sat_R5();
    t_cal_R9();
    t_midstream_R10();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule